// File: doc/BRIEF.md
# DDR SDRAM Power-Up Sequencer

This block takes a DDR SDRAM controller from reset to a usable state. A one-cycle start pulse launches a fixed script. First it sends five command words to the controller, one at a time, each over a valid/ready handshake:

- close all banks;
- turn on the device DLL through the extended mode register;
- load the mode register with the DLL-reset bit set;
- close all banks again;
- run one auto-refresh.

After the commands, the block writes the controller's refresh-interval register and then its timing-parameter register. It finishes with the width-dependent setup registers. It then waits out the DLL settle time counted from the mode-register load, and raises a sticky done flag.

A 4-bit configuration number selects the CAS latency placed in the mode word and the base value of the timing-parameter word. The low nibble of the parameter word always repeats the mode word's CAS field, so the two registers cannot disagree. A width-select input chooses between two endings. The x16 ending writes the extended memory-setup register. The x32 ending writes the strobe-enable and auto-precharge-enable registers together. Programmable gaps keep the next step off the bus for a while after a close-all-banks command and after an auto-refresh command.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, cmd_valid, every register strobe and done are low.
- R2: After start, the accepted command words are, in order: 0x8000_0000 (close all banks, bit 31), 0x0000_2002 (extended mode, DLL on), the mode word, 0x8000_0000 again, and 0x4000_0000 (auto-refresh, bit 30). The register writes follow in order: refresh interval, then timing parameters, then width setup.
- R3: A command stays on cmd_word with cmd_valid high and the word unchanged until cmd_ready is seen high. Each command is issued exactly once.
- R4: The mode word is 0x100 (DLL reset, bit 8) | CAS<<4 (bits 6:4) | 0x8 (interleaved, bit 3) | 0x2 (burst of four, bits 2:0). CAS is 4 when cfg_id[3:2]=0, 2 when cfg_id[3:2]=3, and 3 otherwise.
- R5: The timing-parameter word is written with parm_we. Before its low nibble is replaced by mode-word bits 7:4, its value is a base minus cfg_id[1:0]*0x0100_0000. The base is 0x0511_1180 when cfg_id[3]=0 and 0x0510_0080 when cfg_id[3]=1.
- R6: The refresh-interval value, 0x0000_1080 by default, is written with a single rfsh_we pulse on reg_wdata.
- R7: With x16_sel high, a single xmem_we pulse writes 1. With x16_sel low, strobe_we and autopre_we pulse together in the same cycle and write 1. At most one of these write groups is active in any cycle.
- R8: After a close-all-banks command is accepted, exactly PRE_GAP cycles pass with no command or strobe. After an auto-refresh is accepted, exactly ARF_GAP quiet cycles pass before the refresh-interval write.
- R9: done rises more than DLL_WAIT cycles after the cycle in which the mode-register command was accepted.
- R10: done stays high until reset. A start pulse while the sequence is running, or after it has finished, causes no command and no restart.
- R11: cfg_id and x16_sel are captured on the start cycle. Changes to them afterwards do not alter any word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that launches the sequence from idle |
| cfg_id | input | 4 | Configuration number selecting CAS latency and parameter base |
| x16_sel | input | 1 | High for x16 devices, low for x32 |
| cmd_word | output | 32 | Command word toward the controller |
| cmd_valid | output | 1 | Command word is valid |
| cmd_ready | input | 1 | Controller accepts the command this cycle |
| rfsh_we | output | 1 | Refresh-interval register write strobe |
| parm_we | output | 1 | Timing-parameter register write strobe |
| xmem_we | output | 1 | Extended memory-setup register write strobe |
| strobe_we | output | 1 | Strobe-enable register write strobe |
| autopre_we | output | 1 | Auto-precharge-enable register write strobe |
| reg_wdata | output | 32 | Data for whichever register strobe is active |
| done | output | 1 | Sequence complete and DLL settled (sticky) |

## Verification
The hardest behaviour to reach is a command held under back-pressure while the gap counter is running. On its own, the bench's fast-ready pattern never holds a command for even one cycle. The bench therefore adds a stall mode in which cmd_ready is high only on every third cycle. This keeps each command waiting for varying lengths of time, and the bench checks that the word stays stable and that the quiet gaps are still measured from acceptance. In the same runs, cfg_id and x16_sel are flipped just after start, and extra start pulses are sent both mid-sequence and after done. These cover capture on the start cycle and the ignoring of start.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   typedef logic [31:0] word_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE1,
      ST_EMR,
      ST_MRS,
      ST_PRE2,
      ST_ARF,
      ST_RFSH,
      ST_PARM,
      ST_WIDTH,
      ST_SETTLE,
      ST_DONE
   } seq_state_e;

   localparam word_t CMD_CLOSE_ALL = 32'h8000_0000;
   localparam word_t CMD_REFRESH   = 32'h4000_0000;
   localparam word_t CMD_EXT_MODE  = 32'h0000_2002;

   // CAS latency chosen by the two high configuration bits
   function automatic logic [2:0] cas_for_id(input logic [3:0] id);
      logic [2:0] c;
      case (id[3:2])
         2'd0:    c = 3'd4;
         2'd3:    c = 3'd2;
         default: c = 3'd3;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int MAX = 4,
   parameter int W   = $clog2(MAX + 2)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   AST_TMR_RANGE: assert property (@(posedge clk) disable iff (rst)
      load |-> (int'(load_val) <= MAX)); // R8

   AST_TMR_DRAIN: assert property (@(posedge clk) disable iff (rst)
      (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9

endmodule

// File: rtl/ddr_init_cfg.sv
module ddr_init_cfg
   import ddr_init_pkg::*;
#(
   parameter bit         LATCH_CFG  = 1'b1,
   parameter logic [2:0] BURST_CODE = 3'b010,
   parameter bit         INTERLEAVE = 1'b1,
   parameter word_t      PARM_BASE_A = 32'h0511_1180,
   parameter word_t      PARM_BASE_B = 32'h0510_0080,
   parameter word_t      PARM_STEP   = 32'h0100_0000
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       capture,
   input  logic [3:0] cfg_id,
   input  logic       x16_sel,
   output word_t      mode_word,
   output word_t      parm_word,
   output logic       use_x16
);

   logic [3:0] id_sel;
   logic [2:0] cas;
   word_t      parm_raw;

   generate
      if (LATCH_CFG) begin : g_latched
         logic [3:0] id_q;
         logic       x16_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               id_q  <= '0;
               x16_q <= 1'b0;
            end else if (capture) begin
               id_q  <= cfg_id;
               x16_q <= x16_sel;
            end
         end
         assign id_sel  = id_q;
         assign use_x16 = x16_q;

         AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
            !capture |=> ($stable(mode_word) && $stable(parm_word) && $stable(use_x16))); // R11
      end else begin : g_live
         assign id_sel  = cfg_id;
         assign use_x16 = x16_sel;
      end
   endgenerate

   always_comb begin
      cas       = cas_for_id(id_sel);
      mode_word = {23'd0, 1'b1, 1'b0, cas, INTERLEAVE, BURST_CODE};
      parm_raw  = (id_sel[3] ? PARM_BASE_B : PARM_BASE_A)
                  - (word_t'(id_sel[1:0]) * PARM_STEP);
      parm_word = {parm_raw[31:4], mode_word[7:4]};
   end

   AST_CAS_LEGAL: assert property (@(posedge clk) disable iff (rst)
      (mode_word[6:4] inside {3'd2, 3'd3, 3'd4})); // R4

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
   import ddr_init_pkg::*;
#(
   parameter int    PRE_GAP  = 2,
   parameter int    ARF_GAP  = 4,
   parameter int    DLL_WAIT = 200,
   parameter word_t RFSH_VAL = 32'h0000_1080,
   parameter int    GAP_W    = 3,
   parameter int    SET_W    = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  word_t            mode_word,
   input  word_t            parm_word,
   input  logic             use_x16,
   output logic             capture,
   output word_t            cmd_word,
   output logic             cmd_valid,
   input  logic             cmd_ready,
   output logic             rfsh_we,
   output logic             parm_we,
   output logic             xmem_we,
   output logic             strobe_we,
   output logic             autopre_we,
   output word_t            reg_wdata,
   output logic             done,
   output logic             gap_load,
   output logic [GAP_W-1:0] gap_val,
   input  logic             gap_zero,
   output logic             settle_load,
   output logic [SET_W-1:0] settle_val,
   input  logic             settle_zero
);

   seq_state_e state_q, state_d;
   logic       accept;

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   assign accept     = cmd_valid && cmd_ready;
   assign settle_val = SET_W'(DLL_WAIT);

   always_comb begin
      state_d     = state_q;
      capture     = 1'b0;
      cmd_valid   = 1'b0;
      cmd_word    = '0;
      rfsh_we     = 1'b0;
      parm_we     = 1'b0;
      xmem_we     = 1'b0;
      strobe_we   = 1'b0;
      autopre_we  = 1'b0;
      reg_wdata   = '0;
      done        = 1'b0;
      gap_load    = 1'b0;
      gap_val     = GAP_W'(PRE_GAP);
      settle_load = 1'b0;
      case (state_q)
         ST_IDLE: begin
            capture = start;
            if (start) state_d = ST_PRE1;
         end
         ST_PRE1, ST_PRE2: begin
            cmd_valid = gap_zero;
            cmd_word  = CMD_CLOSE_ALL;
            gap_load  = accept;
            if (accept) state_d = (state_q == ST_PRE1) ? ST_EMR : ST_ARF;
         end
         ST_EMR: begin
            cmd_valid = gap_zero;
            cmd_word  = CMD_EXT_MODE;
            if (accept) state_d = ST_MRS;
         end
         ST_MRS: begin
            cmd_valid   = gap_zero;
            cmd_word    = mode_word;
            settle_load = accept;
            if (accept) state_d = ST_PRE2;
         end
         ST_ARF: begin
            cmd_valid = gap_zero;
            cmd_word  = CMD_REFRESH;
            gap_load  = accept;
            gap_val   = GAP_W'(ARF_GAP);
            if (accept) state_d = ST_RFSH;
         end
         ST_RFSH: begin
            if (gap_zero) begin
               rfsh_we   = 1'b1;
               reg_wdata = RFSH_VAL;
               state_d   = ST_PARM;
            end
         end
         ST_PARM: begin
            parm_we   = 1'b1;
            reg_wdata = parm_word;
            state_d   = ST_WIDTH;
         end
         ST_WIDTH: begin
            xmem_we    = use_x16;
            strobe_we  = !use_x16;
            autopre_we = !use_x16;
            reg_wdata  = 32'd1;
            state_d    = ST_SETTLE;
         end
         ST_SETTLE: begin
            if (settle_zero) state_d = ST_DONE;
         end
         ST_DONE: done = 1'b1;
         default: state_d = ST_IDLE;
      endcase
   end

   // cycles elapsed since the mode-register command was accepted
   logic [SET_W-1:0] since_mrs_q;
   always_ff @(posedge clk) begin
      if (rst)
         since_mrs_q <= '0;
      else if (settle_load)
         since_mrs_q <= '0;
      else if (int'(since_mrs_q) < DLL_WAIT)
         since_mrs_q <= since_mrs_q + 1'b1;
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!cmd_valid && !done && !rfsh_we && !parm_we && !xmem_we && !strobe_we)); // R1

   AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word))); // R3

   AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rfsh_we, parm_we, xmem_we, strobe_we})); // R7

   AST_DLL_SETTLE: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> (int'(since_mrs_q) >= DLL_WAIT)); // R9

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
      done |=> done); // R10

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int         PRE_GAP     = 2,
   parameter int         ARF_GAP     = 4,
   parameter int         DLL_WAIT    = 200,
   parameter logic [31:0] RFSH_VAL   = 32'h0000_1080,
   parameter logic [31:0] PARM_BASE_A = 32'h0511_1180,
   parameter logic [31:0] PARM_BASE_B = 32'h0510_0080,
   parameter logic [31:0] PARM_STEP   = 32'h0100_0000,
   parameter logic [2:0] BURST_CODE  = 3'b010,
   parameter bit         INTERLEAVE  = 1'b1,
   parameter bit         LATCH_CFG   = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        start,
   input  logic [3:0]  cfg_id,
   input  logic        x16_sel,
   output logic [31:0] cmd_word,
   output logic        cmd_valid,
   input  logic        cmd_ready,
   output logic        rfsh_we,
   output logic        parm_we,
   output logic        xmem_we,
   output logic        strobe_we,
   output logic        autopre_we,
   output logic [31:0] reg_wdata,
   output logic        done
);

   localparam int GAP_MAX = (PRE_GAP > ARF_GAP) ? PRE_GAP : ARF_GAP;
   localparam int GAP_W   = $clog2(GAP_MAX + 2);
   localparam int SET_W   = $clog2(DLL_WAIT + 2);

   generate
      if (PRE_GAP < 0 || ARF_GAP < 0) begin : g_bad_gap
         $error("ddr_init_seq: gap parameters must not be negative");
      end
      if (DLL_WAIT < 1) begin : g_bad_wait
         $error("ddr_init_seq: DLL_WAIT must be at least 1");
      end
      if (BURST_CODE == 3'b000) begin : g_bad_burst
         $error("ddr_init_seq: BURST_CODE must select a burst length");
      end
   endgenerate

   word_t            mode_word, parm_word;
   logic             use_x16, capture;
   logic             gap_load, gap_zero, settle_load, settle_zero;
   logic [GAP_W-1:0] gap_val;
   logic [SET_W-1:0] settle_val;

   ddr_init_cfg #(
      .LATCH_CFG  (LATCH_CFG),
      .BURST_CODE (BURST_CODE),
      .INTERLEAVE (INTERLEAVE),
      .PARM_BASE_A(PARM_BASE_A),
      .PARM_BASE_B(PARM_BASE_B),
      .PARM_STEP  (PARM_STEP)
   ) u_cfg (
      .clk      (clk),
      .rst      (rst),
      .capture  (capture),
      .cfg_id   (cfg_id),
      .x16_sel  (x16_sel),
      .mode_word(mode_word),
      .parm_word(parm_word),
      .use_x16  (use_x16)
   );

   ddr_init_timer #(.MAX(GAP_MAX), .W(GAP_W)) u_gap (
      .clk     (clk),
      .rst     (rst),
      .load    (gap_load),
      .load_val(gap_val),
      .zero    (gap_zero)
   );

   ddr_init_timer #(.MAX(DLL_WAIT), .W(SET_W)) u_settle (
      .clk     (clk),
      .rst     (rst),
      .load    (settle_load),
      .load_val(settle_val),
      .zero    (settle_zero)
   );

   ddr_init_fsm #(
      .PRE_GAP (PRE_GAP),
      .ARF_GAP (ARF_GAP),
      .DLL_WAIT(DLL_WAIT),
      .RFSH_VAL(RFSH_VAL),
      .GAP_W   (GAP_W),
      .SET_W   (SET_W)
   ) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .mode_word  (mode_word),
      .parm_word  (parm_word),
      .use_x16    (use_x16),
      .capture    (capture),
      .cmd_word   (cmd_word),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .rfsh_we    (rfsh_we),
      .parm_we    (parm_we),
      .xmem_we    (xmem_we),
      .strobe_we  (strobe_we),
      .autopre_we (autopre_we),
      .reg_wdata  (reg_wdata),
      .done       (done),
      .gap_load   (gap_load),
      .gap_val    (gap_val),
      .gap_zero   (gap_zero),
      .settle_load(settle_load),
      .settle_val (settle_val),
      .settle_zero(settle_zero)
   );

endmodule

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;

   localparam int PRE_GAP  = 2;
   localparam int ARF_GAP  = 3;
   localparam int DLL_WAIT = 40;
   localparam int K_CMD = 0, K_RFSH = 1, K_PARM = 2, K_XMEM = 3, K_NARROW = 4, K_BAD = 7;

   typedef struct {
      int          kind;
      logic [31:0] word;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [3:0]  cfg_id = 4'd0;
   logic        x16_sel = 1'b0;
   logic        cmd_ready = 1'b1;
   logic [31:0] cmd_word, reg_wdata;
   logic        cmd_valid, rfsh_we, parm_we, xmem_we, strobe_we, autopre_we, done;

   int    total = 0, fails = 0, cyc = 0;
   bit    stall = 1'b0;
   item_t exp_q[$];

   always #2 clk = ~clk;

   ddr_init_seq #(.PRE_GAP(PRE_GAP), .ARF_GAP(ARF_GAP), .DLL_WAIT(DLL_WAIT)) u_dut (
      .clk(clk), .rst(rst), .start(start), .cfg_id(cfg_id), .x16_sel(x16_sel),
      .cmd_word(cmd_word), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .rfsh_we(rfsh_we), .parm_we(parm_we), .xmem_we(xmem_we),
      .strobe_we(strobe_we), .autopre_we(autopre_we), .reg_wdata(reg_wdata), .done(done)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_cas(input logic [3:0] id);
      return (id[3:2] == 2'd0) ? 32'd4 : (id[3:2] == 2'd3) ? 32'd2 : 32'd3;
   endfunction

   function automatic logic [31:0] exp_mode(input logic [3:0] id);
      return 32'h100 | (exp_cas(id) << 4) | 32'h8 | 32'h2;
   endfunction

   function automatic logic [31:0] exp_parm(input logic [3:0] id);
      logic [31:0] p;
      p = (id[3] ? 32'h0510_0080 : 32'h0511_1180) - ({30'd0, id[1:0]} * 32'h0100_0000);
      p[3:0] = exp_cas(id)[3:0];
      return p;
   endfunction

   task automatic push(input int kind, input logic [31:0] word, input string tag);
      item_t it;
      it.kind = kind; it.word = word; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic compare(input int kind, input logic [31:0] word);
      item_t it;
      if (exp_q.size() == 0) begin
         check(1'b0, "R2 unexpected output item", word, 32'h0);
      end else begin
         it = exp_q.pop_front();
         check(kind == it.kind && word == it.word, it.tag, word, it.word);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      #1;
      cmd_ready = stall ? (cyc % 3 == 0) : 1'b1;
   end

   // monitor: pops expected items and checks handshake, gaps and settle time
   int          pend = 0, idle = 0, cmd_idx = 0, mrs_cyc = 0;
   bit          prev_wait = 0, prev_done = 0;
   logic [31:0] prev_word = '0;
   always @(negedge clk) begin
      if (rst) begin
         pend = 0; prev_wait = 0; prev_done = 0; cmd_idx = 0;
      end else begin
         if (prev_wait)
            check(cmd_valid && cmd_word == prev_word, "R3 stalled command held", cmd_word, prev_word);
         if (pend != 0) begin
            if (cmd_valid || rfsh_we || parm_we || xmem_we || strobe_we || autopre_we) begin
               if (pend == 1) check(idle == PRE_GAP, "R8 quiet gap after close-all", idle, PRE_GAP);
               else           check(idle == ARF_GAP, "R8 quiet gap after refresh", idle, ARF_GAP);
               pend = 0;
            end else idle++;
         end
         if (cmd_valid && cmd_ready) begin
            compare(K_CMD, cmd_word);
            cmd_idx++;
            if (cmd_idx == 3) mrs_cyc = cyc;
            if (cmd_word == 32'h8000_0000) begin pend = 1; idle = 0; end
            else if (cmd_word == 32'h4000_0000) begin pend = 2; idle = 0; end
         end
         if (rfsh_we) compare(K_RFSH, reg_wdata);
         if (parm_we) compare(K_PARM, reg_wdata);
         if (xmem_we) compare(K_XMEM, reg_wdata);
         if (strobe_we || autopre_we) compare((strobe_we && autopre_we) ? K_NARROW : K_BAD, reg_wdata);
         if (done && !prev_done)
            check(cyc - mrs_cyc > DLL_WAIT, "R9 settle time before done", cyc - mrs_cyc, DLL_WAIT + 1);
         prev_wait = cmd_valid && !cmd_ready;
         prev_word = cmd_word;
         prev_done = done;
      end
   end

   task automatic check_reset_state();
      check(!cmd_valid && !done && !rfsh_we && !parm_we && !xmem_we && !strobe_we && !autopre_we,
            "R1 quiet after reset",
            {25'd0, cmd_valid, done, rfsh_we, parm_we, xmem_we, strobe_we, autopre_we}, 32'h0);
   endtask

   task automatic do_reset();
      @(posedge clk); #1 rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check_reset_state();
   endtask

   task automatic run_seq(input logic [3:0] id, input bit x16, input bit stl, input bit flip, input bit poke);
      bit got_done;
      got_done = 1'b0;
      push(K_CMD, 32'h8000_0000, "R2 first close-all");
      push(K_CMD, 32'h0000_2002, "R2 extended mode word");
      push(K_CMD, exp_mode(id), flip ? "R11 mode word from captured id" : "R4 mode word");
      push(K_CMD, 32'h8000_0000, "R2 second close-all");
      push(K_CMD, 32'h4000_0000, "R2 auto-refresh");
      push(K_RFSH, 32'h0000_1080, "R6 refresh interval write");
      push(K_PARM, exp_parm(id), flip ? "R11 parameter from captured id" : "R5 parameter word");
      push(x16 ? K_XMEM : K_NARROW, 32'd1, "R7 width setup write");
      stall = stl;
      @(posedge clk); #1;
      start = 1'b1; cfg_id = id; x16_sel = x16;
      @(posedge clk); #1;
      start = 1'b0;
      if (flip) begin cfg_id = ~id; x16_sel = ~x16; end
      if (poke) begin
         repeat (4) @(posedge clk);
         #1 start = 1'b1;
         @(posedge clk); #1 start = 1'b0;
      end
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (done) begin got_done = 1'b1; break; end
      end
      check(got_done, "R9 done reached", {31'd0, done}, 32'd1);
      check(exp_q.size() == 0, "R2 all items produced", exp_q.size(), 32'd0);
      exp_q.delete();
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check(done && !cmd_valid, "R10 start ignored after done",
               {30'd0, done, cmd_valid}, 32'd2);
      end
      stall = 1'b0;
      do_reset();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check_reset_state();
      run_seq(4'd0,  1'b0, 1'b0, 1'b0, 1'b0);
      run_seq(4'd5,  1'b1, 1'b1, 1'b1, 1'b1);
      run_seq(4'd11, 1'b0, 1'b1, 1'b0, 1'b0);
      run_seq(4'd14, 1'b1, 1'b0, 1'b0, 1'b1);
      run_seq(4'd15, 1'b0, 1'b0, 1'b1, 1'b0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #800000;
      total++;
      fails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule